// File: doc/BRIEF.md
# Mask-Driven Lane Compress/Expand Unit

This unit takes a vector of `LANES` data lanes with a `LANES`-bit selection mask and rearranges the lanes in one of three ways. In pack modes, the chosen lanes move to the bottom of the output vector and keep their relative order. The lanes above them are either cleared to zero or, in the sheep-and-goats variant, filled with the unchosen lanes, also in their original order. In scatter mode the operation runs in reverse: the lowest input lanes move out, in order, to the chosen positions, and every unchosen position reads zero. Every mode also reports how many mask bits are set.

Each lane's destination comes from two exclusive prefix counts, which are built as log-depth parallel-prefix adder trees. The first counts the chosen lanes below each lane. The second counts the unchosen lanes below each lane and adds the population count, so each unchosen lane lands above the packed region. Mixing the two counts under the mask gives a collision-free permutation.

Vectors enter and leave on valid/ready streams, one vector per transfer. A vector is accepted when `in_valid` and `in_ready` are both high on a clock edge, and its result appears on the output one cycle later. While `out_valid` is high and `out_ready` is low, the output holds and `in_ready` stays low. When the output register is empty, or is being drained in the same cycle, `in_ready` is high, so full throughput is kept.

Top module: `vcompress_unit`

## Requirements
- R1: A vector accepted on a clock edge (`in_valid` and `in_ready` both high) is presented with `out_valid` high after that edge.
- R2: While `out_valid` is high and `out_ready` is low, `out_data` and `out_count` hold their values and `in_ready` is low. `in_ready` is high whenever `out_valid` is low.
- R3: `out_count` equals the number of set bits in the accepted `in_mask`, in every mode.
- R4: With `in_mode` = 0 (pack, zero fill), output lane k (k < count) holds the k-th chosen input lane, counting from lane 0 upward.
- R5: With `in_mode` = 0, every output lane at index count or above is zero. An all-zero mask therefore yields an all-zero vector and count 0.
- R6: With `in_mode` = 1 (pack, sheep-and-goats), the lowest lanes are packed as in R4. Output lane count+m then holds the m-th unchosen input lane, counting upward.
- R7: With `in_mode` = 2 (scatter), the k-th chosen output position, counting upward, holds input lane k. Unchosen output lanes are zero.
- R8: `in_mode` = 3 behaves exactly like `in_mode` = 0.
- R9: During reset `out_valid` is low and `in_ready` is high.

Lane i occupies bits `[i*DW +: DW]` of `in_data` and `out_data`. Mask bit i belongs to lane i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input vector is offered |
| in_ready | output | 1 | Unit can take the offered vector |
| in_data | input | LANES*DW | Input lanes |
| in_mask | input | LANES | Lane selection mask |
| in_mode | input | 2 | 0 pack/zero, 1 pack/sheep-and-goats, 2 scatter, 3 as 0 |
| out_valid | output | 1 | Result vector is offered |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | LANES*DW | Result lanes |
| out_count | output | $clog2(LANES+1) | Population count of the accepted mask |

## Verification
Two events can fall in the same cycle: the consumer draining the held result, and the producer handing in the next vector. The bench provokes this by driving `in_valid` and `out_ready` on unrelated periodic patterns. The result is that drains coincide with new acceptances, with stalls, and with idle gaps. Every delivered result is matched in order against a scoreboard computed arithmetically from the mask and mode. Held values and the low `in_ready` are also checked during every stall cycle.

// File: rtl/vcmp_pkg.sv
package vcmp_pkg;
  typedef enum logic [1:0] {
    VC_PACK_ZERO = 2'd0,
    VC_PACK_SAG  = 2'd1,
    VC_SCATTER   = 2'd2,
    VC_PACK_ALT  = 2'd3
  } vc_mode_e;
endpackage

// File: rtl/vcmp_prefix.sv
// Exclusive prefix population count over a bit vector, log-depth adder tree.
module vcmp_prefix #(
  parameter int N  = 8,
  parameter int CW = $clog2(N + 1)
) (
  input  logic [N-1:0]    bits_i,
  output logic [N*CW-1:0] excl_o,
  output logic [CW-1:0]   total_o
);
  localparam int LV = (N > 1) ? $clog2(N) : 1;

  logic [CW-1:0] stage [0:LV][0:N-1];

  for (genvar i = 0; i < N; i++) begin : g_seed
    assign stage[0][i] = CW'(bits_i[i]);
  end

  for (genvar l = 0; l < LV; l++) begin : g_level
    for (genvar i = 0; i < N; i++) begin : g_node
      if (i >= (1 << l)) begin : g_add
        assign stage[l+1][i] = stage[l][i] + stage[l][i-(1<<l)];
      end else begin : g_pass
        assign stage[l+1][i] = stage[l][i];
      end
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_out
    assign excl_o[i*CW +: CW] = stage[LV][i] - CW'(bits_i[i]);
  end

  assign total_o = stage[LV][N-1];
endmodule

// File: rtl/vcmp_index.sv
// Blends the chosen-lane and unchosen-lane prefix counts into pack destinations.
module vcmp_index #(
  parameter int N  = 8,
  parameter int CW = $clog2(N + 1)
) (
  input  logic [N-1:0]    mask_i,
  input  logic [N*CW-1:0] sel_excl_i,
  input  logic [N*CW-1:0] rej_excl_i,
  input  logic [CW-1:0]   pop_i,
  output logic [N*CW-1:0] dst_o
);
  for (genvar i = 0; i < N; i++) begin : g_lane
    assign dst_o[i*CW +: CW] = mask_i[i] ? sel_excl_i[i*CW +: CW]
                                         : rej_excl_i[i*CW +: CW] + pop_i;
  end
endmodule

// File: rtl/vcmp_route.sv
// Lane crossbar: scatter-by-destination for pack modes, gather for scatter mode.
module vcmp_route
  import vcmp_pkg::*;
#(
  parameter int N  = 8,
  parameter int DW = 16,
  parameter int CW = $clog2(N + 1)
) (
  input  logic [N*DW-1:0] data_i,
  input  logic [N-1:0]    mask_i,
  input  logic [N*CW-1:0] dst_i,
  input  logic [N*CW-1:0] sel_excl_i,
  input  logic [CW-1:0]   pop_i,
  input  vc_mode_e        mode_i,
  output logic [N*DW-1:0] data_o
);
  logic [N*DW-1:0] packed_v;
  logic [N*DW-1:0] spread_v;

  always_comb begin
    packed_v = '0;
    for (int j = 0; j < N; j++) begin
      logic [DW-1:0] acc;
      acc = '0;
      for (int i = 0; i < N; i++) begin
        if (dst_i[i*CW +: CW] == CW'(j)) acc = acc | data_i[i*DW +: DW];
      end
      if (mode_i == VC_PACK_SAG || CW'(j) < pop_i) packed_v[j*DW +: DW] = acc;
    end
  end

  always_comb begin
    spread_v = '0;
    for (int i = 0; i < N; i++) begin
      logic [DW-1:0] pick;
      pick = '0;
      for (int k = 0; k < N; k++) begin
        if (sel_excl_i[i*CW +: CW] == CW'(k)) pick = data_i[k*DW +: DW];
      end
      if (mask_i[i]) spread_v[i*DW +: DW] = pick;
    end
  end

  assign data_o = (mode_i == VC_SCATTER) ? spread_v : packed_v;
endmodule

// File: rtl/vcompress_unit.sv
module vcompress_unit
  import vcmp_pkg::*;
#(
  parameter int LANES = 8,
  parameter int DW    = 16,
  localparam int CW   = $clog2(LANES + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [LANES*DW-1:0] in_data,
  input  logic [LANES-1:0]    in_mask,
  input  logic [1:0]          in_mode,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [LANES*DW-1:0] out_data,
  output logic [CW-1:0]       out_count
);
  logic [LANES*CW-1:0] sel_excl, rej_excl, dst;
  logic [CW-1:0]       pop, rej_total;
  logic [LANES*DW-1:0] routed;
  vc_mode_e            mode_in;

  logic                valid_q;
  logic [LANES*DW-1:0] data_q;
  logic [CW-1:0]       count_q;
  vc_mode_e            mode_q;

  assign mode_in = vc_mode_e'(in_mode);

  vcmp_prefix #(.N(LANES), .CW(CW)) u_sel_pfx (
    .bits_i(in_mask), .excl_o(sel_excl), .total_o(pop)
  );

  vcmp_prefix #(.N(LANES), .CW(CW)) u_rej_pfx (
    .bits_i(~in_mask), .excl_o(rej_excl), .total_o(rej_total)
  );

  vcmp_index #(.N(LANES), .CW(CW)) u_index (
    .mask_i(in_mask), .sel_excl_i(sel_excl), .rej_excl_i(rej_excl),
    .pop_i(pop), .dst_o(dst)
  );

  vcmp_route #(.N(LANES), .DW(DW), .CW(CW)) u_route (
    .data_i(in_data), .mask_i(in_mask), .dst_i(dst), .sel_excl_i(sel_excl),
    .pop_i(pop), .mode_i(mode_in), .data_o(routed)
  );

  assign in_ready = !valid_q || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
      count_q <= '0;
      mode_q  <= VC_PACK_ZERO;
    end else if (in_ready) begin
      valid_q <= in_valid;
      if (in_valid) begin
        data_q  <= routed;
        count_q <= pop;
        mode_q  <= (mode_in == VC_PACK_ALT) ? VC_PACK_ZERO : mode_in;
      end
    end
  end

  assign out_valid = valid_q;
  assign out_data  = data_q;
  assign out_count = count_q;

  logic unused_ok;
  assign unused_ok = ^rej_total;
endmodule

// File: rtl/vcompress_unit_chk.sv
module vcompress_unit_chk
  import vcmp_pkg::*;
#(
  parameter int LANES = 8,
  parameter int DW    = 16,
  parameter int CW    = $clog2(LANES + 1)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic                in_ready,
  input logic [LANES-1:0]    in_mask,
  input logic                out_valid,
  input logic                out_ready,
  input logic [LANES*DW-1:0] out_data,
  input logic [CW-1:0]       out_count,
  input vc_mode_e            mode_q
);
  p_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_count));

  p_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  p_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_count == $past(CW'($countones(in_mask))));

  p_count_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_count <= CW'(LANES));

  for (genvar j = 0; j < LANES; j++) begin : g_upper
    p_upper_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && mode_q == VC_PACK_ZERO && out_count <= CW'(j)
        |-> out_data[j*DW +: DW] == '0);
  end
endmodule

bind vcompress_unit vcompress_unit_chk #(.LANES(LANES), .DW(DW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_mask(in_mask), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .out_count(out_count), .mode_q(mode_q)
);

// File: tb/vcompress_unit_tb.sv
module vcompress_unit_tb;
  localparam int L   = 4;
  localparam int DW  = 8;
  localparam int CW  = $clog2(L + 1);
  localparam int TOTAL = 2 * 4 * (1 << L);

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid, in_ready, out_valid, out_ready;
  logic [L*DW-1:0] in_data, out_data;
  logic [L-1:0]    in_mask;
  logic [1:0]      in_mode;
  logic [CW-1:0]   out_count;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  vcompress_unit #(.LANES(L), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_mask(in_mask), .in_mode(in_mode),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_count(out_count)
  );

  function automatic logic [L*DW-1:0] model(input logic [L*DW-1:0] d,
                                            input logic [L-1:0] m,
                                            input logic [1:0] md);
    logic [L*DW-1:0] r;
    int k;
    r = '0;
    k = 0;
    if (md == 2'd2) begin
      for (int i = 0; i < L; i++)
        if (m[i]) begin r[i*DW +: DW] = d[k*DW +: DW]; k++; end
    end else begin
      for (int i = 0; i < L; i++)
        if (m[i]) begin r[k*DW +: DW] = d[i*DW +: DW]; k++; end
      if (md == 2'd1)
        for (int i = 0; i < L; i++)
          if (!m[i]) begin r[k*DW +: DW] = d[i*DW +: DW]; k++; end
    end
    return r;
  endfunction

  function automatic string tag_of(input logic [1:0] md);
    case (md)
      2'd0: return "R4/R5";
      2'd1: return "R6";
      2'd2: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  logic [L*DW-1:0] q_data [$];
  logic [CW-1:0]   q_cnt  [$];
  logic [1:0]      q_mode [$];

  initial begin
    int idx, cyc;
    bit stall_prev, acc_prev;
    logic [L*DW-1:0] prev_data;
    logic [CW-1:0]   prev_cnt;
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
    in_data = '0; in_mask = '0; in_mode = '0;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R9 out_valid", 64'(out_valid), 64'd0);
    check(in_ready == 1'b1, "R9 in_ready", 64'(in_ready), 64'd1);
    rst_n = 1'b1;
    idx = 0; cyc = 0; stall_prev = 0; acc_prev = 0;
    prev_data = '0; prev_cnt = '0;
    while ((idx < TOTAL || q_data.size() > 0) && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      out_ready = (cyc > 400) ? 1'b1 : ((cyc % 4) != 3);
      if (idx < TOTAL && (cyc % 7) != 6) begin
        int seed;
        seed = idx / 64;
        in_valid = 1'b1;
        in_mask  = L'(idx % 16);
        in_mode  = 2'((idx / 16) % 4);
        for (int i = 0; i < L; i++)
          in_data[i*DW +: DW] = seed ? DW'(8'hF0 - 3*i) : DW'(8'h11 * (i + 1));
      end else begin
        in_valid = 1'b0;
      end
      #1;
      if (stall_prev) begin
        check(out_data == prev_data && out_count == prev_cnt && out_valid,
              "R2 hold", 64'(out_data), 64'(prev_data));
      end
      if (out_valid && !out_ready)
        check(!in_ready, "R2 in_ready low", 64'(in_ready), 64'd0);
      if (!out_valid)
        check(in_ready, "R2 in_ready high", 64'(in_ready), 64'd1);
      if (acc_prev) check(out_valid, "R1 latency", 64'(out_valid), 64'd1);
      if (out_valid && out_ready) begin
        if (q_data.size() == 0) begin
          check(1'b0, "R1 unexpected output", 64'(out_data), 64'd0);
        end else begin
          logic [L*DW-1:0] ed;
          logic [CW-1:0]   ec;
          logic [1:0]      em;
          ed = q_data.pop_front(); ec = q_cnt.pop_front(); em = q_mode.pop_front();
          check(out_data == ed, tag_of(em), 64'(out_data), 64'(ed));
          check(out_count == ec, "R3 count", 64'(out_count), 64'(ec));
        end
      end
      stall_prev = out_valid && !out_ready;
      prev_data = out_data;
      prev_cnt = out_count;
      acc_prev = in_valid && in_ready;
      if (acc_prev) begin
        q_data.push_back(model(in_data, in_mask, in_mode));
        q_cnt.push_back(CW'($countones(in_mask)));
        q_mode.push_back(in_mode);
        idx++;
      end
    end
    if (idx < TOTAL || q_data.size() > 0) begin
      checks++;
      errors++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", idx, TOTAL);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule